// File: doc/BRIEF.md
# Bidirectional Port with Change Interrupt

This block is an eight-bit general-purpose I/O port that a CPU controls through a small register bus. Each pin has a direction bit and an output latch bit. An input pin has its driver released. An output pin drives the latch value. One active-low option bit turns on weak pull-ups on every pin that is an input. Pins set as outputs never receive a pull-up.

The upper four pins can raise a change interrupt. A pin takes part only while it is set as an input. Its synchronized level is compared with a snapshot. The snapshot is captured each time software reads or writes the port register, so the comparison is not made against the value of the previous cycle. Any participating pin that differs from the snapshot sets a sticky flag. While the difference lasts, the flag keeps being set again, so software must first touch the port and then clear the flag. A set flag also raises a wake request for the power controller.

The register bus has a two-bit select, separate write and read strobes, and a combinational read path. Pin levels pass through a two-stage synchronizer before they are read back or compared.

Top module: `chgint_port`

## Requirements
- R1: Register select 1 holds the direction bits, and they reset to all ones. A direction bit of 1 makes the pin an input with `pin_oe` low. A direction bit of 0 sets `pin_oe` high and drives the output latch bit (select 0) on `pin_out`.
- R2: A read of select 0 returns the synchronized pin level for input bits and the latch bit for output bits. A pin change appears in the read data after two clock edges.
- R3: `pull_en[i]` is high only when bit i is an input and the pull-up control is 0. An output pin never has `pull_en` high.
- R4: The pull-up control is bit 7 of select 2 and is active low. It resets to 1, so all pull-ups are off after reset. A read of select 2 returns the control at bit 7 and zeros elsewhere.
- R5: Only bits 7 to 4 take part in the change comparison. A change on bits 3 to 0, or on an upper bit that is set as an output, never sets the flag.
- R6: A participating input bit sets the flag while its synchronized level differs from the snapshot taken at the last port access. The flag rises on the third clock edge after the pin changes. A pin that returns to its snapshot value ends the mismatch, but the flag stays set.
- R7: Any read or write of select 0 captures a new snapshot and so ends the mismatch. A write to select 3 with bit 0 equal to 0 clears the flag. A read of select 3 returns the flag at bit 0.
- R8: If a mismatch is present in the same cycle as a clear, the flag stays set. A clear issued before a port access therefore has no effect.
- R9: `wake_req` is high whenever the change flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Register select: 0 port, 1 direction, 2 option, 3 interrupt control |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_rd | input | 1 | Read strobe; a read of select 0 captures the snapshot |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Output latch value for the pads |
| pin_oe | output | 8 | Output enable per pin (1 drives the pin) |
| pull_en | output | 8 | Weak pull-up enable per pin |
| chg_flag | output | 1 | Sticky change-interrupt flag |
| wake_req | output | 1 | Wake request while the flag is set |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume that a strobe refers only to the register named by `bus_sel`, so a direction write is followed by one cycle in which no other register changes. The bench drives one bus access at a time at the falling clock edge and leaves an idle cycle between accesses. It changes `pin_in` only at falling edges and holds it for at least three edges before it judges the flag, so the synchronizer latency never overlaps a check.

// File: rtl/chgint_port_pkg.sv
package chgint_port_pkg;

    typedef enum logic [1:0] {
        SEL_PORT = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_OPT  = 2'd2,
        SEL_INTC = 2'd3
    } reg_sel_e;

    // bit positions that software relies on
    localparam int unsigned PU_N_BIT = 7;
    localparam int unsigned FLAG_BIT = 0;

    typedef struct packed {
        logic wr_port;
        logic wr_dir;
        logic wr_opt;
        logic wr_intc;
        logic port_touch;
    } bus_dec_t;

    function automatic bus_dec_t decode_bus(input logic [1:0] sel,
                                            input logic       wr,
                                            input logic       rd);
        bus_dec_t d;
        d.wr_port    = wr && (sel == SEL_PORT);
        d.wr_dir     = wr && (sel == SEL_DIR);
        d.wr_opt     = wr && (sel == SEL_OPT);
        d.wr_intc    = wr && (sel == SEL_INTC);
        d.port_touch = (wr || rd) && (sel == SEL_PORT);
        return d;
    endfunction

endpackage

// File: rtl/chgint_sync.sv
module chgint_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/chgint_regs.sv
module chgint_regs
    import chgint_port_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_port,
    input  logic         wr_dir,
    input  logic         wr_opt,
    input  logic         wr_intc,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] lat_q,
    output logic         pu_n_q,
    output logic         clr_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '1;
            lat_q  <= '0;
            pu_n_q <= 1'b1;
        end else begin
            if (wr_dir)  dir_q  <= wdata;
            if (wr_port) lat_q  <= wdata;
            if (wr_opt)  pu_n_q <= wdata[PU_N_BIT];
        end
    end

    // writing 0 to the flag bit requests a clear; writing 1 does nothing
    assign clr_req = wr_intc && !wdata[FLAG_BIT];
endmodule

// File: rtl/chgint_pads.sv
module chgint_pads #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] lat_q,
    input  logic         pu_n_q,
    input  logic [W-1:0] pin_s,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pull_en,
    output logic [W-1:0] port_rd
);
    always_comb begin
        pin_out = lat_q;
        pin_oe  = ~dir_q;
        pull_en = dir_q & {W{~pu_n_q}};
        port_rd = (dir_q & pin_s) | (~dir_q & lat_q);
    end
endmodule

// File: rtl/chgint_change.sv
module chgint_change #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         touch,
    input  logic         clr_req,
    input  logic [N-1:0] pin_hi,
    input  logic [N-1:0] dir_hi,
    output logic         mismatch,
    output logic         flag
);
    logic [N-1:0] snap;
    logic [N-1:0] diff;

    always_comb begin
        diff     = (pin_hi ^ snap) & dir_hi;
        mismatch = |diff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
            flag <= 1'b0;
        end else begin
            if (touch) snap <= pin_hi;
            if (mismatch)     flag <= 1'b1;
            else if (clr_req) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/chgint_port.sv
module chgint_port
    import chgint_port_pkg::*;
#(
    parameter int unsigned W      = 8,
    parameter int unsigned CHG_LO = 4,
    parameter int unsigned SYNC_N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   bus_sel,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pull_en,
    output logic         chg_flag,
    output logic         wake_req
);
    localparam int unsigned CHG_N = W - CHG_LO;

    bus_dec_t     dec;
    logic [W-1:0] pin_s;
    logic [W-1:0] dir_q;
    logic [W-1:0] lat_q;
    logic         pu_n_q;
    logic         clr_req;
    logic [W-1:0] port_rd;
    logic         chg_mismatch;

    assign dec = decode_bus(bus_sel, bus_wr, bus_rd);

    chgint_sync #(.W(W), .STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_s)
    );

    chgint_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_port (dec.wr_port),
        .wr_dir  (dec.wr_dir),
        .wr_opt  (dec.wr_opt),
        .wr_intc (dec.wr_intc),
        .wdata   (bus_wdata),
        .dir_q   (dir_q),
        .lat_q   (lat_q),
        .pu_n_q  (pu_n_q),
        .clr_req (clr_req)
    );

    chgint_pads #(.W(W)) u_pads (
        .dir_q   (dir_q),
        .lat_q   (lat_q),
        .pu_n_q  (pu_n_q),
        .pin_s   (pin_s),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .pull_en (pull_en),
        .port_rd (port_rd)
    );

    chgint_change #(.N(CHG_N)) u_chg (
        .clk      (clk),
        .rst      (rst),
        .touch    (dec.port_touch),
        .clr_req  (clr_req),
        .pin_hi   (pin_s[W-1:CHG_LO]),
        .dir_hi   (dir_q[W-1:CHG_LO]),
        .mismatch (chg_mismatch),
        .flag     (chg_flag)
    );

    assign wake_req = chg_flag;

    always_comb begin
        bus_rdata = '0;
        unique case (reg_sel_e'(bus_sel))
            SEL_PORT: bus_rdata = port_rd;
            SEL_DIR:  bus_rdata = dir_q;
            SEL_OPT:  bus_rdata[PU_N_BIT] = pu_n_q;
            SEL_INTC: bus_rdata[FLAG_BIT] = chg_flag;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/chgint_port_chk.sv
module chgint_port_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   bus_sel,
    input logic         bus_wr,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] pin_oe,
    input logic [W-1:0] pull_en,
    input logic         chg_flag,
    input logic         mismatch
);
    // R1: a direction write shows up on the output enables one cycle later
    a_r1_oe_after_dir: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_sel == 2'd1) |=> (pin_oe == ~$past(bus_wdata)));

    // R3: a driven pin never has its pull-up on
    a_r3_no_pull_on_output: assert property (@(posedge clk) disable iff (rst)
        ((pull_en & pin_oe) == '0));

    // R4: after an option write, every input pull-up follows the active-low control
    a_r4_pull_follows_opt: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_sel == 2'd2) |=>
        (pull_en == (~pin_oe & {W{~$past(bus_wdata[7])}})));

    // R6: a flag rise always traces back to a mismatch
    a_r6_rise_needs_mismatch: assert property (@(posedge clk) disable iff (rst)
        $rose(chg_flag) |-> $past(mismatch));

    // R8: a mismatch sets the flag even when a clear arrives in the same cycle
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        mismatch |=> chg_flag);

    // R7: a clear with no mismatch pending drops the flag
    a_r7_clear_works: assert property (@(posedge clk) disable iff (rst)
        (chg_flag && !mismatch && bus_wr && bus_sel == 2'd3 && !bus_wdata[0])
        |=> !chg_flag);
endmodule

bind chgint_port chgint_port_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .pull_en   (pull_en),
    .chg_flag  (chg_flag),
    .mismatch  (chg_mismatch)
);

// File: tb/chgint_port_bench.sv
module chgint_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_sel = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic [7:0] pull_en;
    logic       chg_flag;
    logic       wake_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    chgint_port u_chgint_port (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pull_en   (pull_en),
        .chg_flag  (chg_flag),
        .wake_req  (wake_req)
    );

    // stimulus table: direction, latch, pins, active-low pull control
    localparam logic [7:0] T_DIR [6] = '{8'hFF, 8'h00, 8'hF0, 8'h0F, 8'hAA, 8'h5A};
    localparam logic [7:0] T_LAT [6] = '{8'h00, 8'h3C, 8'h0F, 8'h96, 8'h55, 8'hC3};
    localparam logic [7:0] T_PIN [6] = '{8'hA5, 8'h5A, 8'hC3, 8'h69, 8'hFF, 8'h00};
    localparam logic       T_PUN [6] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        bus_sel = sel; bus_wdata = data; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] data);
        @(negedge clk);
        bus_sel = sel; bus_rd = 1'b1;
        #1 data = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_pins(input logic [7:0] v, input int edges);
        @(negedge clk);
        pin_in = v;
        repeat (edges) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk("R1 reset oe", pin_oe, 8'h00);
        chk("R4 reset pull", pull_en, 8'h00);
        chk("R9 reset flag/wake", {6'b0, chg_flag, wake_req}, 8'h00);
        rd(2'd1, r); chk("R1 reset dir", r, 8'hFF);
        rd(2'd2, r); chk("R4 reset option", r, 8'h80);

        // table walk
        for (int i = 0; i < 6; i++) begin
            wr(2'd1, T_DIR[i]);
            wr(2'd0, T_LAT[i]);
            wr(2'd2, {T_PUN[i], 7'b0});
            set_pins(T_PIN[i], 3);
            chk("R1 oe", pin_oe, ~T_DIR[i]);
            chk("R1 out", pin_out, T_LAT[i]);
            chk("R3 pull", pull_en, T_PUN[i] ? 8'h00 : T_DIR[i]);
            rd(2'd0, r);
            chk("R2 port read", r, (T_DIR[i] & T_PIN[i]) | (~T_DIR[i] & T_LAT[i]));
        end
        rd(2'd2, r); chk("R4 option read", r, 8'h00);

        // settle: all inputs, pull-ups off, pins low, fresh snapshot, flag cleared
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'h80);
        set_pins(8'h00, 3);
        rd(2'd0, r);
        wr(2'd3, 8'h00);
        chk("R7 cleared", {7'b0, chg_flag}, 8'h00);

        // low bits never participate
        set_pins(8'h0F, 5);
        chk("R5 low bits ignored", {7'b0, chg_flag}, 8'h00);

        // latency and wake
        set_pins(8'h2F, 2);
        chk("R6 not yet after two edges", {7'b0, chg_flag}, 8'h00);
        @(negedge clk);
        chk("R6 flag after three edges", {7'b0, chg_flag}, 8'h01);
        chk("R9 wake", {7'b0, wake_req}, 8'h01);
        rd(2'd3, r); chk("R7 flag readback", r, 8'h01);

        // clear before port access does not stick
        wr(2'd3, 8'h00);
        chk("R8 clear blocked by mismatch", {7'b0, chg_flag}, 8'h01);
        repeat (4) @(negedge clk);
        wr(2'd3, 8'h00);
        chk("R8 clear still blocked", {7'b0, chg_flag}, 8'h01);

        // read ends mismatch, then clear works
        rd(2'd0, r);
        wr(2'd3, 8'h00);
        chk("R7 read then clear", {7'b0, chg_flag}, 8'h00);
        chk("R9 wake drops", {7'b0, wake_req}, 8'h00);

        // return to snapshot value ends mismatch without a port access
        set_pins(8'h6F, 3);
        chk("R6 second change sets", {7'b0, chg_flag}, 8'h01);
        set_pins(8'h2F, 3);
        chk("R6 flag sticky", {7'b0, chg_flag}, 8'h01);
        wr(2'd3, 8'h00);
        chk("R6 back to snapshot allows clear", {7'b0, chg_flag}, 8'h00);

        // write access ends mismatch
        set_pins(8'h0F, 3);
        chk("R6 falling change sets", {7'b0, chg_flag}, 8'h01);
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h00);
        chk("R7 write then clear", {7'b0, chg_flag}, 8'h00);

        // writing 1 to the flag bit does not clear
        set_pins(8'h8F, 3);
        wr(2'd3, 8'h01);
        chk("R7 write of 1 no clear", {7'b0, chg_flag}, 8'h01);
        rd(2'd0, r);
        wr(2'd3, 8'h00);

        // upper bits as outputs are excluded
        wr(2'd1, 8'h0F);
        rd(2'd0, r);
        wr(2'd3, 8'h00);
        set_pins(8'h7F, 5);
        chk("R5 output bits excluded", {7'b0, chg_flag}, 8'h00);
        chk("R3 outputs not pulled", pull_en & pin_oe, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule